// File: doc/BRIEF.md
# Frequency-Domain Tuner and Bin Decimator

This block sits between a forward FFT and an inverse FFT in a fast-convolution receiver. It takes one slice of FFT bins at a time, presented in natural order with a slice number. It tunes the wanted carrier to zero frequency by rotating bin indices by a programmable tuning bin, at a step of one bin (62.5 kHz at 64 MHz sampling with 1024 bins). It removes the phase slip that the rotation causes between overlapping slices, and weights each bin by a stored complex filter response. It then keeps only a narrow block of bins around zero frequency, and the size of that block sets the output sample rate. All of this work happens in one pass as the bins stream in.

The kept bins go into one bank of a double buffer, at the position the inverse FFT expects. When the last bin of a slice arrives, that bank is streamed out in natural inverse-FFT order while the other bank fills with the next slice. The filter response is loaded through a simple write port. The tuning bin, the rate code and the slice number are taken once per slice, with the first bin.

Two small state machines run the block. The fill machine has the states SEEK and FILL. It moves from SEEK to FILL when a first-bin marker arrives. It moves from FILL back to SEEK when the final bin (index NFFT-1) is accepted. A new first-bin marker during FILL restarts the slice. The drain machine has the states IDLE and DRAIN. It moves from IDLE to DRAIN on slice completion, and from DRAIN back to IDLE after the last kept bin has been emitted.

Top module: `fft_bin_tuner`

## Requirements
- R1: After reset, out_valid, out_sop and out_eop are low, and nothing is emitted until a complete slice has been accepted.
- R2: Bins that arrive with in_valid high while no slice is open (before the first in_sop, or after a slice's final bin) are ignored. Even a full slice's worth of them produces no output.
- R3: With tuning bin k, the kept bin at shifted index d (0..NFFT-1) is taken from input bin (d + k) mod NFFT. Input bins are numbered 0..NFFT-1 from the in_sop beat.
- R4: Rate code r (rate_sel, 0..3) keeps N = (NFFT/4) >> r bins: 256, 128, 64 or 32 at the defaults. Output beat m carries shifted index d = m for m < N/2, and d = NFFT - N + m for the remaining beats.
- R5: Each kept bin of slice n is multiplied by (-j)^q, where q = (3·k·n) mod 4. This is the correction exp(-j·2π·k·768·n/1024) for a hop of three quarters of a slice.
- R6: The rotated bin is multiplied by the complex coefficient stored at index d. Both coefficient parts are signed with 15 fraction bits. Each product part is shifted right arithmetically by 15 (floor) and output as an exact 18-bit signed value.
- R7: tune_bin, rate_sel and in_slice are sampled only on the in_sop beat. Changes during the rest of the slice have no effect on that slice.
- R8: The first output beat is in the cycle after the clock edge that accepts the final bin. N beats follow on consecutive cycles, out_sop is high on the first, out_eop is high on the last, and out_valid falls afterwards.
- R9: A new slice may start while the previous one is still draining, and both come out correct.
- R10: A write with coef_we high stores coef_re and coef_im at index coef_addr. It applies to all bins accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 10 | Coefficient index (shifted bin) |
| coef_re | input | 16 | Coefficient real part, signed with 15 fraction bits |
| coef_im | input | 16 | Coefficient imaginary part, signed with 15 fraction bits |
| tune_bin | input | 10 | Tuning bin k |
| rate_sel | input | 2 | Rate code r |
| in_valid | input | 1 | Input bin valid |
| in_sop | input | 1 | Marks bin 0 of a slice |
| in_slice | input | 8 | Slice number n |
| in_re | input | 16 | Input bin real part |
| in_im | input | 16 | Input bin imaginary part |
| out_valid | output | 1 | Output bin valid |
| out_sop | output | 1 | First output bin of a slice |
| out_eop | output | 1 | Last output bin of a slice |
| out_re | output | 18 | Output bin real part |
| out_im | output | 18 | Output bin imaginary part |

## Verification
No output depends on a bin until the slice is complete. The first kept bin therefore appears exactly one cycle after the edge that accepts bin NFFT-1, and beat m appears m cycles after that. The bench drives each bin on a falling edge. It then checks the drained beats on the falling edges that follow, one per cycle, and expects out_valid low one cycle after the last beat. In the back-to-back case, the next slice is driven on the same falling edges on which the previous drain is checked.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

    typedef enum logic {
        W_SEEK,
        W_FILL
    } fill_state_e;

    typedef enum logic {
        R_IDLE,
        R_DRAIN
    } drain_state_e;

    // Number of quarter turns of phase slip for tuning bin k at slice n,
    // with a hop of hopq quarter slices. Only the low two bits matter.
    function automatic logic [1:0] quarter_turns(input int unsigned hopq,
                                                 input int unsigned k,
                                                 input int unsigned n);
        int unsigned prod;
        prod = hopq * k * n;
        return prod[1:0];
    endfunction

endpackage

// File: rtl/fbt_quarter_rot.sv
module fbt_quarter_rot #(
    parameter int DW = 16
) (
    input  logic [1:0]          q,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    output logic signed [DW:0]   y_re,
    output logic signed [DW:0]   y_im
);
    logic signed [DW:0] ext_re;
    logic signed [DW:0] ext_im;

    assign ext_re = {a_re[DW-1], a_re};
    assign ext_im = {a_im[DW-1], a_im};

    // Multiply by (-j)^q; one extra bit keeps the negated minimum exact.
    always_comb begin
        unique case (q)
            2'd0: begin y_re = ext_re;  y_im = ext_im;  end
            2'd1: begin y_re = ext_im;  y_im = -ext_re; end
            2'd2: begin y_re = -ext_re; y_im = -ext_im; end
            2'd3: begin y_re = -ext_im; y_im = ext_re;  end
        endcase
    end
endmodule

// File: rtl/fbt_cmul.sv
module fbt_cmul #(
    parameter int XW = 17,
    parameter int CW = 16,
    parameter int OW = 18
) (
    input  logic signed [XW-1:0] x_re,
    input  logic signed [XW-1:0] x_im,
    input  logic signed [CW-1:0] c_re,
    input  logic signed [CW-1:0] c_im,
    output logic signed [OW-1:0] y_re,
    output logic signed [OW-1:0] y_im
);
    localparam int SUMW = XW + CW + 1;

    logic signed [SUMW-1:0] sum_re;
    logic signed [SUMW-1:0] sum_im;

    assign sum_re = SUMW'(x_re) * SUMW'(c_re) - SUMW'(x_im) * SUMW'(c_im);
    assign sum_im = SUMW'(x_re) * SUMW'(c_im) + SUMW'(x_im) * SUMW'(c_re);

    // Drop the coefficient fraction bits with floor rounding.
    assign y_re = OW'(sum_re >>> (CW - 1));
    assign y_im = OW'(sum_im >>> (CW - 1));
endmodule

// File: rtl/fbt_coef_store.sv
module fbt_coef_store #(
    parameter int NFFT = 1024,
    parameter int CW   = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(NFFT)-1:0]  waddr,
    input  logic signed [CW-1:0]     wr_re,
    input  logic signed [CW-1:0]     wr_im,
    input  logic [$clog2(NFFT)-1:0]  raddr,
    output logic signed [CW-1:0]     rd_re,
    output logic signed [CW-1:0]     rd_im
);
    logic [2*CW-1:0] mem [NFFT];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {wr_re, wr_im};
        end
    end

    assign rd_re = $signed(mem[raddr][2*CW-1:CW]);
    assign rd_im = $signed(mem[raddr][CW-1:0]);
endmodule

// File: rtl/fbt_bank_buf.sv
module fbt_bank_buf #(
    parameter int DEPTH = 256,
    parameter int W     = 36
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic                      wsel,
    input  logic [$clog2(DEPTH)-1:0]  waddr,
    input  logic [W-1:0]              wdata,
    input  logic                      rsel,
    input  logic [$clog2(DEPTH)-1:0]  raddr,
    output logic [W-1:0]              rdata
);
    logic [W-1:0] bank_rd [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wsel == 1'(g))) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_rd[g] = mem[raddr];
    end

    assign rdata = rsel ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/fft_bin_tuner.sv
module fft_bin_tuner
    import fbt_pkg::*;
#(
    parameter int NFFT         = 1024,
    parameter int DW           = 16,
    parameter int CW           = 16,
    parameter int SW           = 8,
    parameter int RATES        = 4,
    parameter int HOP_QUARTERS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         coef_we,
    input  logic [$clog2(NFFT)-1:0]      coef_addr,
    input  logic signed [CW-1:0]         coef_re,
    input  logic signed [CW-1:0]         coef_im,
    input  logic [$clog2(NFFT)-1:0]      tune_bin,
    input  logic [$clog2(RATES)-1:0]     rate_sel,
    input  logic                         in_valid,
    input  logic                         in_sop,
    input  logic [SW-1:0]                in_slice,
    input  logic signed [DW-1:0]         in_re,
    input  logic signed [DW-1:0]         in_im,
    output logic                         out_valid,
    output logic                         out_sop,
    output logic                         out_eop,
    output logic signed [DW+1:0]         out_re,
    output logic signed [DW+1:0]         out_im
);
    localparam int BW   = $clog2(NFFT);
    localparam int NMAX = NFFT / 4;
    localparam int PW   = $clog2(NMAX);
    localparam int KW   = PW + 1;
    localparam int RSW  = $clog2(RATES);
    localparam int XW   = DW + 1;
    localparam int OW   = DW + 2;

    fill_state_e  fill_q,  fill_d;
    drain_state_e drain_q, drain_d;

    logic [BW-1:0]  bin_cnt;
    logic [BW-1:0]  lat_k;
    logic [RSW-1:0] lat_rate;
    logic [SW-1:0]  lat_n;
    logic           wbank;
    logic           rbank;
    logic [PW-1:0]  rptr;
    logic [KW-1:0]  rlen;

    logic           slice_start;
    logic           accept;
    logic           slice_done;
    logic [BW-1:0]  cur_k;
    logic [RSW-1:0] cur_rate;
    logic [SW-1:0]  cur_n;
    logic [BW-1:0]  bin_idx;
    logic [BW-1:0]  shifted;
    logic [KW-1:0]  nkeep;
    logic [KW-1:0]  nhalf;
    logic [BW-1:0]  neg_half;
    logic           in_low;
    logic           in_high;
    logic           keep;
    logic [PW-1:0]  pos;
    logic           wr_en;
    logic [1:0]     qturn;
    logic           drain_last;

    logic signed [XW-1:0] rot_re, rot_im;
    logic signed [CW-1:0] cf_re, cf_im;
    logic signed [OW-1:0] prod_re, prod_im;
    logic [2*OW-1:0]      rd_word;

    // Per-bin decode: slice-constant values come straight from the ports on
    // the first bin, from the latches on the rest.
    always_comb begin
        slice_start = in_valid && in_sop;
        cur_k       = slice_start ? tune_bin : lat_k;
        cur_rate    = slice_start ? rate_sel : lat_rate;
        cur_n       = slice_start ? in_slice : lat_n;
        bin_idx     = slice_start ? '0 : bin_cnt;
        accept      = in_valid && (slice_start || (fill_q == W_FILL));
        slice_done  = accept && (bin_idx == BW'(NFFT - 1));
        shifted     = bin_idx - cur_k;
        nkeep       = KW'(NMAX) >> cur_rate;
        nhalf       = nkeep >> 1;
        neg_half    = BW'(0) - BW'(nhalf);
        in_low      = shifted < BW'(nhalf);
        in_high     = shifted >= neg_half;
        keep        = in_low || in_high;
        pos         = PW'(in_low ? shifted : shifted + BW'(nkeep));
        wr_en       = accept && keep;
        qturn       = quarter_turns(HOP_QUARTERS, 32'(cur_k), 32'(cur_n));
        drain_last  = ({1'b0, rptr} == rlen - KW'(1));
    end

    fbt_quarter_rot #(.DW(DW)) u_rot (
        .q    (qturn),
        .a_re (in_re),
        .a_im (in_im),
        .y_re (rot_re),
        .y_im (rot_im)
    );

    fbt_coef_store #(.NFFT(NFFT), .CW(CW)) u_coef (
        .clk   (clk),
        .we    (coef_we),
        .waddr (coef_addr),
        .wr_re (coef_re),
        .wr_im (coef_im),
        .raddr (shifted),
        .rd_re (cf_re),
        .rd_im (cf_im)
    );

    fbt_cmul #(.XW(XW), .CW(CW), .OW(OW)) u_mul (
        .x_re (rot_re),
        .x_im (rot_im),
        .c_re (cf_re),
        .c_im (cf_im),
        .y_re (prod_re),
        .y_im (prod_im)
    );

    fbt_bank_buf #(.DEPTH(NMAX), .W(2*OW)) u_buf (
        .clk   (clk),
        .we    (wr_en),
        .wsel  (wbank),
        .waddr (pos),
        .wdata ({prod_re, prod_im}),
        .rsel  (rbank),
        .raddr (rptr),
        .rdata (rd_word)
    );

    // Next-state logic of both machines.
    always_comb begin
        fill_d = fill_q;
        unique case (fill_q)
            W_SEEK: if (slice_start) fill_d = W_FILL;
            W_FILL: if (slice_done)  fill_d = W_SEEK;
        endcase

        drain_d = drain_q;
        unique case (drain_q)
            R_IDLE:  if (slice_done) drain_d = R_DRAIN;
            R_DRAIN: begin
                if (slice_done)      drain_d = R_DRAIN;
                else if (drain_last) drain_d = R_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q  <= W_SEEK;
            drain_q <= R_IDLE;
        end else begin
            fill_q  <= fill_d;
            drain_q <= drain_d;
        end
    end

    // Counters, latches and bank pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_cnt  <= '0;
            lat_k    <= '0;
            lat_rate <= '0;
            lat_n    <= '0;
            wbank    <= 1'b0;
            rbank    <= 1'b0;
            rptr     <= '0;
            rlen     <= KW'(NMAX);
        end else begin
            if (accept) begin
                bin_cnt <= bin_idx + BW'(1);
            end
            if (slice_start) begin
                lat_k    <= tune_bin;
                lat_rate <= rate_sel;
                lat_n    <= in_slice;
            end
            if (slice_done) begin
                wbank <= ~wbank;
                rbank <= wbank;
                rlen  <= nkeep;
                rptr  <= '0;
            end else if (drain_q == R_DRAIN) begin
                rptr <= rptr + PW'(1);
            end
        end
    end

    // Output decode.
    always_comb begin
        out_valid = (drain_q == R_DRAIN);
        out_sop   = out_valid && (rptr == '0);
        out_eop   = out_valid && drain_last;
        out_re    = $signed(rd_word[2*OW-1:OW]);
        out_im    = $signed(rd_word[OW-1:0]);
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !slice_start) |=> ($stable(lat_k) && $stable(lat_rate) && $stable(lat_n)))
        else $error("slice settings changed mid-slice");

    // R8
    frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |=> (!out_valid || out_sop))
        else $error("output continued past end of slice");

    // R9
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slice_done |-> (drain_q == R_IDLE))
        else $error("slice completed while previous drain still running");

    // R4
    wr_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, pos} < nkeep))
        else $error("kept bin written beyond output length");

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == W_SEEK && drain_q == R_IDLE && !slice_done) |=> !out_valid)
        else $error("output without a completed slice");
endmodule

// File: tb/tb_fft_bin_tuner.sv
module tb_fft_bin_tuner;
    localparam int NFFT = 64;
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int SW   = 8;
    localparam int BW   = 6;
    localparam int NMAX = NFFT / 4;
    localparam int OW   = DW + 2;
    localparam int HOPQ = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coef_we = 1'b0;
    logic [BW-1:0] coef_addr = '0;
    logic signed [CW-1:0] coef_re = '0;
    logic signed [CW-1:0] coef_im = '0;
    logic [BW-1:0] tune_bin = '0;
    logic [1:0] rate_sel = '0;
    logic in_valid = 1'b0;
    logic in_sop = 1'b0;
    logic [SW-1:0] in_slice = '0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic out_valid, out_sop, out_eop;
    logic signed [OW-1:0] out_re, out_im;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int cr [NFFT];
    int ci [NFFT];

    always #2 clk = ~clk;

    fft_bin_tuner #(.NFFT(NFFT), .DW(DW), .CW(CW), .SW(SW), .RATES(4), .HOP_QUARTERS(HOPQ)) dut (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_re(coef_re), .coef_im(coef_im), .tune_bin(tune_bin), .rate_sel(rate_sel),
        .in_valid(in_valid), .in_sop(in_sop), .in_slice(in_slice), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_re(out_re), .out_im(out_im)
    );

    function automatic int dat_re(int j, int s);
        if (s == 9) return -32768;
        return ((j * 397 + s * 1231 + 5) % 65536) - 32768;
    endfunction

    function automatic int dat_im(int j, int s);
        if (s == 9) return -32768;
        return ((j * 1733 + s * 211 + 90) % 65536) - 32768;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_slice(int s, int k, int r, int n, bit mess);
        for (int j = 0; j < NFFT; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (j == 0);
            in_re    = DW'(dat_re(j, s));
            in_im    = DW'(dat_im(j, s));
            if (j == 0 || !mess) begin
                tune_bin = BW'(k);
                rate_sel = 2'(r);
                in_slice = SW'(n);
            end else begin
                tune_bin = BW'(k + j);
                rate_sel = 2'(r + 1);
                in_slice = SW'(n + 3);
            end
        end
    endtask

    task automatic drain_check(int s, int k, int r, int n, bit stop_in);
        int nk = NMAX >> r;
        int q  = (HOPQ * k * n) % 4;
        for (int m = 0; m < nk; m++) begin
            int d, j;
            longint a, b, xr, xi, pr, pi, er, ei;
            @(negedge clk);
            if (m == 0 && stop_in) begin
                in_valid = 1'b0;
                in_sop = 1'b0;
            end
            d = (m < nk / 2) ? m : NFFT - nk + m;
            j = (d + k) % NFFT;
            a = dat_re(j, s);
            b = dat_im(j, s);
            case (q)
                0: begin xr = a;  xi = b;  end
                1: begin xr = b;  xi = -a; end
                2: begin xr = -a; xi = -b; end
                default: begin xr = -b; xi = a; end
            endcase
            pr = xr * cr[d] - xi * ci[d];
            pi = xr * ci[d] + xi * cr[d];
            er = pr >>> 15;
            ei = pi >>> 15;
            chk(out_valid == 1'b1, "R8 valid beat", longint'(out_valid), 1);
            chk(out_sop == (m == 0), "R8 sop", longint'(out_sop), longint'(m == 0));
            chk(out_eop == (m == nk - 1), "R4 R8 eop", longint'(out_eop), longint'(m == nk - 1));
            chk(longint'(out_re) == er, "R3 R4 R5 R6 real", longint'(out_re), er);
            chk(longint'(out_im) == ei, "R3 R4 R5 R6 imag", longint'(out_im), ei);
        end
    endtask

    task automatic idle_check(string tag, int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, tag, longint'(out_valid), 0);
        end
    endtask

    task automatic stray_bins();
        for (int j = 0; j < NFFT + 8; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop = 1'b0;
            in_re = DW'(j);
            in_im = DW'(-j);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R2 stray bins", longint'(out_valid), 0);
        idle_check("R2 stray bins", 12);
    endtask

    task automatic write_coef(int d, int re, int im);
        @(negedge clk);
        coef_we = 1'b1;
        coef_addr = BW'(d);
        coef_re = CW'(re);
        coef_im = CW'(im);
        cr[d] = re;
        ci[d] = im;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s = 0;
        int klist [6] = '{0, 1, 2, 3, 17, 63};
        repeat (3) @(negedge clk);
        // R1
        chk(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
        chk(out_sop == 1'b0, "R1 reset sop", longint'(out_sop), 0);
        chk(out_eop == 1'b0, "R1 reset eop", longint'(out_eop), 0);
        rst_n = 1'b1;
        // R10: load the full coefficient table
        for (int d = 0; d < NFFT; d++) begin
            @(negedge clk);
            coef_we = 1'b1;
            coef_addr = BW'(d);
            cr[d] = ((d * 911 + 77) % 65536) - 32768;
            ci[d] = ((d * 577 + 3) % 65536) - 32768;
            coef_re = CW'(cr[d]);
            coef_im = CW'(ci[d]);
        end
        @(negedge clk);
        coef_we = 1'b0;
        idle_check("R1 no output before slice", 4);

        // R2: bins with no open slice
        stray_bins();

        // R3 R4 R5 R6: sweep rate, tuning bin and slice number
        for (int r = 0; r < 4; r++) begin
            for (int ki = 0; ki < 6; ki++) begin
                for (int n = 0; n < 4; n++) begin
                    send_slice(s, klist[ki], r, n, 1'b0);
                    drain_check(s, klist[ki], r, n, 1'b1);
                    @(negedge clk);
                    chk(out_valid == 1'b0, "R8 idle after drain", longint'(out_valid), 0);
                    s++;
                end
            end
        end

        // R2: again after a completed slice
        stray_bins();

        // R7: settings changed during the slice are ignored
        send_slice(9, 5, 1, 3, 1'b1);
        drain_check(9, 5, 1, 3, 1'b1);
        send_slice(40, 33, 3, 2, 1'b1);
        drain_check(40, 33, 3, 2, 1'b1);
        @(negedge clk);

        // R9: back-to-back slices overlapping the drain
        send_slice(50, 7, 0, 1, 1'b0);
        fork
            send_slice(51, 12, 2, 2, 1'b0);
            drain_check(50, 7, 0, 1, 1'b0);
        join
        fork
            send_slice(52, 60, 1, 3, 1'b0);
            drain_check(51, 12, 2, 2, 1'b0);
        join
        drain_check(52, 60, 1, 3, 1'b1);
        idle_check("R9 idle after chain", 3);

        // R10: rewrite coefficients at both ends of the kept window
        write_coef(0, -32768, -32768);
        write_coef(NFFT - 1, 32767, -32768);
        send_slice(9, 6, 3, 1, 1'b0);
        drain_check(9, 6, 3, 1, 1'b1);
        idle_check("R10 idle", 2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule